// File: doc/BRIEF.md
# Assisted Translation Buffer Search and Write Unit

This block holds a small, fully associative set of address translation entries, split into several equal arrays. Software never touches the entries directly. It places operand values on a set of assist-register input ports and pulses an operation strobe, and results come back on matching registered output ports. Two operations exist. A write copies the assist-register fields into one entry. A search builds a virtual key and loads the result outputs with either the matching entry or a set of miss defaults. The key is made from an address-space bit, an 8-bit process identifier padded below with eight zero bits, and the low 32 bits of a 64-bit general register, zero-extended.

Control is a four-state machine, and its state register always names the operation accepted at the last clock edge. `ST_IDLE` means no operation was accepted. `ST_SRCH` means a legal search was accepted. `ST_WRT` means a write was accepted. `ST_TRAP` means a search was refused because its RA field was nonzero. The next state follows only the inputs sampled at that edge, so every state can move to every other state:
- no strobe goes to `ST_IDLE`;
- a write strobe goes to `ST_WRT`;
- a search strobe with RA equal to zero goes to `ST_SRCH`;
- a search strobe with RA nonzero goes to `ST_TRAP`.

`done` is high in every state except `ST_IDLE`, and `exc` is high only in `ST_TRAP`.

Top module: `xlat_assist_unit`

## Requirements
- R1: After reset, every entry is invalid. All result outputs are zero, and `done` and `exc` are low.
- R2: With `op_kind`=1 (write), the strobe stores valid, TS, TID, page, attribute, RPN, permission and RPN-high fields into slot `in_sel_arr*DEPTH + in_sel_idx`. The result outputs keep their values, and a later write to the same slot replaces the entry.
- R3: With `op_kind`=0 (search), an entry matches only if all three hold: its valid bit is set, its TS equals `in_srch_as`, and its page equals `op_rb[31:12]`. Bits 63:32 and 11:0 of `op_rb` do not affect the match.
- R4: A stored TID of zero matches any search process ID. Any other stored TID must equal `in_srch_pid`.
- R5: On a hit, the outputs show the matching entry's array and index, valid=1, and that entry's TS, TID, page, attribute, RPN, permission and RPN-high fields.
- R6: On a miss, the outputs show valid=0, TS=`in_srch_as` and TID=`in_srch_pid`. Array, index, page, attribute, RPN, permission and RPN-high are all zero.
- R7: When several entries match, the lowest slot number wins, so array 0 is searched before array 1.
- R8: A search whose `op_ra` is nonzero performs no lookup. It raises `exc` with `done`, and the result outputs stay unchanged. A write ignores `op_ra`.
- R9: `done` is high in the cycle after each strobe and low after a cycle with no strobe. Operations may come back to back, and a search sees an entry written by the operation just before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_kind | input | 1 | 0 = search, 1 = write |
| op_ra | input | 5 | RA operand field; must be zero for search |
| op_rb | input | 64 | General register holding the search address |
| in_sel_arr | input | ARR_W (1) | Write target array |
| in_sel_idx | input | IDX_W (2) | Write target index within the array |
| in_valid | input | 1 | Entry valid bit to write |
| in_ts | input | 1 | Entry address-space bit to write |
| in_tid | input | 8 | Entry process ID to write (0 = global) |
| in_page | input | 20 | Effective page number to write |
| in_attr | input | 5 | Page attributes to write |
| in_rpn | input | 20 | Real page number, low part |
| in_perm | input | 6 | Access permissions to write |
| in_rpn_hi | input | 4 | Upper 4 bits of the real page number |
| in_srch_as | input | 1 | Search address-space bit |
| in_srch_pid | input | 8 | Search process ID |
| out_sel_arr | output | ARR_W (1) | Result array of the hit |
| out_sel_idx | output | IDX_W (2) | Result index of the hit |
| out_valid | output | 1 | Result valid (1 = hit) |
| out_ts | output | 1 | Result address-space bit |
| out_tid | output | 8 | Result process ID |
| out_page | output | 20 | Result effective page |
| out_attr | output | 5 | Result attributes |
| out_rpn | output | 20 | Result real page, low part |
| out_perm | output | 6 | Result permissions |
| out_rpn_hi | output | 4 | Result real page, upper 4 bits |
| done | output | 1 | Operation completed last edge |
| exc | output | 1 | Illegal-form search refused |

## Verification
A corrupted entry, or a wrong match line, can stay hidden until a search uses the key it affects. That search then returns, in the very next cycle, the wrong slot, a miss instead of a hit, or wrong field values. The bench therefore searches right after each write and then again later. A wrong control state shows up at once as a `done` or `exc` pulse in a cycle where none is due, or as result outputs that move after a write or a refused search. The checker watches these properties every cycle.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    parameter int PID_W  = 8;
    parameter int EA_W   = 32;
    parameter int OFS_W  = 12;
    parameter int ATTR_W = 5;
    parameter int RPN_W  = 20;
    parameter int PERM_W = 6;
    parameter int RHI_W  = 4;
    parameter int RA_W   = 5;
    parameter int RB_W   = 64;
    localparam int PAGE_W = EA_W - OFS_W;

    typedef enum logic {
        OPK_SEARCH = 1'b0,
        OPK_WRITE  = 1'b1
    } opk_e;

    typedef struct packed {
        logic              vld;
        logic              ts;
        logic [PID_W-1:0]  tid;
        logic [PAGE_W-1:0] page;
        logic [ATTR_W-1:0] attr;
        logic [RPN_W-1:0]  rpn;
        logic [PERM_W-1:0] perm;
        logic [RHI_W-1:0]  rhi;
    } xent_t;
endpackage

// File: rtl/xlat_store.sv
module xlat_store
    import xlat_pkg::*;
#(
    parameter int SLOTS = 8,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  xent_t             wr_ent,
    input  logic              key_as,
    input  logic [PID_W-1:0]  key_pid,
    input  logic [PAGE_W-1:0] key_page,
    output logic [SLOTS-1:0]  hit_vec,
    input  logic [SLOT_W-1:0] rd_slot,
    output xent_t             rd_ent
);
    xent_t ents [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        xent_t q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en && wr_slot == SLOT_W'(g)) begin
                q <= wr_ent;
            end
        end
        assign ents[g] = q;
        // Key = {AS, PID, 8'h00, 32'h0, EA}; the pad and the upper EA are
        // zero on both sides, so only AS, PID and the page take part.
        assign hit_vec[g] = q.vld && (q.ts == key_as)
                         && ((q.tid == '0) || (q.tid == key_pid))
                         && (q.page == key_page);
    end

    assign rd_ent = ents[rd_slot];
endmodule

// File: rtl/xlat_pick.sv
module xlat_pick #(
    parameter int SLOTS = 8,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic [SLOTS-1:0]  req,
    output logic              any,
    output logic [SLOT_W-1:0] slot
);
    always_comb begin
        any  = |req;
        slot = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (req[i]) slot = SLOT_W'(i);
        end
    end
endmodule

// File: rtl/xlat_assist_unit.sv
module xlat_assist_unit
    import xlat_pkg::*;
#(
    parameter int ARRAYS = 2,
    parameter int DEPTH  = 4,
    localparam int ARR_W  = $clog2(ARRAYS),
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int SLOTS  = ARRAYS * DEPTH,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_kind,
    input  logic [RA_W-1:0]   op_ra,
    input  logic [RB_W-1:0]   op_rb,
    input  logic [ARR_W-1:0]  in_sel_arr,
    input  logic [IDX_W-1:0]  in_sel_idx,
    input  logic              in_valid,
    input  logic              in_ts,
    input  logic [PID_W-1:0]  in_tid,
    input  logic [PAGE_W-1:0] in_page,
    input  logic [ATTR_W-1:0] in_attr,
    input  logic [RPN_W-1:0]  in_rpn,
    input  logic [PERM_W-1:0] in_perm,
    input  logic [RHI_W-1:0]  in_rpn_hi,
    input  logic              in_srch_as,
    input  logic [PID_W-1:0]  in_srch_pid,
    output logic [ARR_W-1:0]  out_sel_arr,
    output logic [IDX_W-1:0]  out_sel_idx,
    output logic              out_valid,
    output logic              out_ts,
    output logic [PID_W-1:0]  out_tid,
    output logic [PAGE_W-1:0] out_page,
    output logic [ATTR_W-1:0] out_attr,
    output logic [RPN_W-1:0]  out_rpn,
    output logic [PERM_W-1:0] out_perm,
    output logic [RHI_W-1:0]  out_rpn_hi,
    output logic              done,
    output logic              exc
);
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SRCH,
        ST_WRT,
        ST_TRAP
    } st_e;

    st_e st_q, st_nxt;

    logic [SLOTS-1:0]  hit_vec;
    logic              hit_any;
    logic [SLOT_W-1:0] hit_slot;
    logic [SLOT_W-1:0] wr_slot;
    xent_t             wr_ent;
    xent_t             rd_ent;
    xent_t             res_q;
    logic [ARR_W-1:0]  res_arr_q;
    logic [IDX_W-1:0]  res_idx_q;
    logic              unused_rb;

    assign unused_rb = ^{op_rb[RB_W-1:EA_W], op_rb[OFS_W-1:0]};

    // Next state: decided only by the strobe sampled at this edge
    always_comb begin
        st_nxt = ST_IDLE;
        if (op_valid) begin
            unique case (opk_e'(op_kind))
                OPK_SEARCH: st_nxt = (op_ra != '0) ? ST_TRAP : ST_SRCH;
                OPK_WRITE:  st_nxt = ST_WRT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nxt;
    end

    // Moore outputs
    always_comb begin
        done = 1'b0;
        exc  = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_SRCH,
            ST_WRT: done = 1'b1;
            ST_TRAP: begin
                done = 1'b1;
                exc  = 1'b1;
            end
        endcase
    end

    assign wr_slot = SLOT_W'(in_sel_arr) * SLOT_W'(DEPTH) + SLOT_W'(in_sel_idx);

    always_comb begin
        wr_ent      = '0;
        wr_ent.vld  = in_valid;
        wr_ent.ts   = in_ts;
        wr_ent.tid  = in_tid;
        wr_ent.page = in_page;
        wr_ent.attr = in_attr;
        wr_ent.rpn  = in_rpn;
        wr_ent.perm = in_perm;
        wr_ent.rhi  = in_rpn_hi;
    end

    xlat_store #(.SLOTS(SLOTS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (st_nxt == ST_WRT),
        .wr_slot  (wr_slot),
        .wr_ent   (wr_ent),
        .key_as   (in_srch_as),
        .key_pid  (in_srch_pid),
        .key_page (op_rb[OFS_W +: PAGE_W]),
        .hit_vec  (hit_vec),
        .rd_slot  (hit_slot),
        .rd_ent   (rd_ent)
    );

    xlat_pick #(.SLOTS(SLOTS)) u_pick (
        .req  (hit_vec),
        .any  (hit_any),
        .slot (hit_slot)
    );

    // Result staging: loaded only on a legal search
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q     <= '0;
            res_arr_q <= '0;
            res_idx_q <= '0;
        end else if (st_nxt == ST_SRCH) begin
            if (hit_any) begin
                res_q     <= rd_ent;
                res_arr_q <= ARR_W'(hit_slot / SLOT_W'(DEPTH));
                res_idx_q <= IDX_W'(hit_slot % SLOT_W'(DEPTH));
            end else begin
                res_q     <= '0;
                res_q.ts  <= in_srch_as;
                res_q.tid <= in_srch_pid;
                res_arr_q <= '0;
                res_idx_q <= '0;
            end
        end
    end

    assign out_sel_arr = res_arr_q;
    assign out_sel_idx = res_idx_q;
    assign out_valid   = res_q.vld;
    assign out_ts      = res_q.ts;
    assign out_tid     = res_q.tid;
    assign out_page    = res_q.page;
    assign out_attr    = res_q.attr;
    assign out_rpn     = res_q.rpn;
    assign out_perm    = res_q.perm;
    assign out_rpn_hi  = res_q.rhi;
endmodule

// File: rtl/xlat_assist_chk.sv
module xlat_assist_chk
    import xlat_pkg::*;
#(
    parameter int ARRAYS = 2,
    parameter int DEPTH  = 4,
    localparam int ARR_W = $clog2(ARRAYS),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic              op_kind,
    input logic [RA_W-1:0]   op_ra,
    input logic [RB_W-1:0]   op_rb,
    input logic              in_srch_as,
    input logic [PID_W-1:0]  in_srch_pid,
    input logic [ARR_W-1:0]  out_sel_arr,
    input logic [IDX_W-1:0]  out_sel_idx,
    input logic              out_valid,
    input logic              out_ts,
    input logic [PID_W-1:0]  out_tid,
    input logic [PAGE_W-1:0] out_page,
    input logic [RPN_W-1:0]  out_rpn,
    input logic              done,
    input logic              exc
);
    logic unused_rb_chk;
    logic trap_req, legal_srch, wr_req;

    assign unused_rb_chk = ^{op_rb[RB_W-1:EA_W], op_rb[OFS_W-1:0]};
    assign trap_req   = op_valid && !op_kind && (op_ra != '0);
    assign legal_srch = op_valid && !op_kind && (op_ra == '0);
    assign wr_req     = op_valid && op_kind;

    AST_STROBE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> done); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !done); // R9
    AST_TRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> exc); // R8
    AST_NO_FALSE_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (legal_srch || wr_req) |=> !exc); // R8
    AST_TRAP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> ($stable(out_valid) && $stable(out_page) && $stable(out_rpn))); // R8
    AST_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> ($stable(out_valid) && $stable(out_tid) && $stable(out_rpn))); // R2
    AST_SEARCH_AS: assert property (@(posedge clk) disable iff (!rst_n)
        legal_srch |=> (out_ts == $past(in_srch_as))); // R3
    AST_SEARCH_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        legal_srch |=> (!out_valid || out_page == $past(op_rb[OFS_W +: PAGE_W]))); // R3
    AST_SEARCH_PID: assert property (@(posedge clk) disable iff (!rst_n)
        legal_srch |=> (out_tid == $past(in_srch_pid) || (out_valid && out_tid == '0))); // R4
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        legal_srch |=> (out_valid || (out_rpn == '0 && out_page == '0
                        && out_sel_arr == '0 && out_sel_idx == '0))); // R6
endmodule

bind xlat_assist_unit xlat_assist_chk #(.ARRAYS(ARRAYS), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/xlat_assist_unit_bench.sv
module xlat_assist_unit_bench;
    localparam int SLOTS = 8;

    typedef struct packed {
        logic        vld;
        logic        ts;
        logic [7:0]  tid;
        logic [19:0] page;
        logic [4:0]  attr;
        logic [19:0] rpn;
        logic [5:0]  perm;
        logic [3:0]  rhi;
    } bent_t;

    typedef struct {
        logic [68:0] v;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0, op_kind = 1'b0;
    logic [4:0]  op_ra = '0;
    logic [63:0] op_rb = '0;
    logic        in_sel_arr = 1'b0;
    logic [1:0]  in_sel_idx = '0;
    logic        in_valid = 1'b0, in_ts = 1'b0, in_srch_as = 1'b0;
    logic [7:0]  in_tid = '0, in_srch_pid = '0;
    logic [19:0] in_page = '0, in_rpn = '0;
    logic [4:0]  in_attr = '0;
    logic [5:0]  in_perm = '0;
    logic [3:0]  in_rpn_hi = '0;
    logic        out_sel_arr, out_valid, out_ts, done, exc;
    logic [1:0]  out_sel_idx;
    logic [7:0]  out_tid;
    logic [19:0] out_page, out_rpn;
    logic [4:0]  out_attr;
    logic [5:0]  out_perm;
    logic [3:0]  out_rpn_hi;

    int    n_chk = 0, n_bad = 0;
    exp_t  sb[$];
    bent_t mdl [SLOTS];
    logic [68:0] cur = '0;
    logic [68:0] act;

    xlat_assist_unit u_xlat_assist_unit (.*);

    always #2.5ns clk = ~clk;

    assign act = {exc, out_sel_arr, out_sel_idx, out_valid, out_ts, out_tid,
                  out_page, out_attr, out_rpn, out_perm, out_rpn_hi};

    task automatic check(input string req, input logic [68:0] a, input logic [68:0] e);
        n_chk++;
        if (a !== e) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, a, e);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Monitor: pop one expected item per done pulse
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                check("R9 unexpected done", 69'(done), 69'(0));
            end else begin
                exp_t it;
                it = sb.pop_front();
                check(it.req, act, it.v);
            end
        end
    end

    task automatic wr(input logic arr, input logic [1:0] idx, input bent_t e,
                      input logic [4:0] ra, input string req);
        exp_t it;
        it.v = cur;
        it.req = req;
        sb.push_back(it);
        mdl[int'(arr) * 4 + int'(idx)] = e;
        op_valid = 1'b1; op_kind = 1'b1; op_ra = ra;
        in_sel_arr = arr; in_sel_idx = idx;
        {in_valid, in_ts, in_tid, in_page, in_attr, in_rpn, in_perm, in_rpn_hi} = e;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic sr(input logic as, input logic [7:0] pid, input logic [63:0] rb,
                      input logic [4:0] ra, input string req);
        exp_t  it;
        bent_t e;
        int    hit;
        hit = -1;
        if (ra != 0) begin
            it.v = {1'b1, cur[67:0]};
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (hit < 0 && mdl[i].vld && mdl[i].ts == as
                    && (mdl[i].tid == 8'h00 || mdl[i].tid == pid)
                    && mdl[i].page == rb[31:12]) hit = i;
            end
            if (hit >= 0) begin
                it.v = {1'b0, 1'(hit / 4), 2'(hit % 4), mdl[hit]};
            end else begin
                e = '0; e.ts = as; e.tid = pid;
                it.v = {1'b0, 1'b0, 2'b00, e};
            end
            cur = it.v;
        end
        it.req = req;
        sb.push_back(it);
        op_valid = 1'b1; op_kind = 1'b0; op_ra = ra; op_rb = rb;
        in_srch_as = as; in_srch_pid = pid;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    initial begin
        #100us;
        n_chk++; n_bad++;
        $display("FAIL R9 watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < SLOTS; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", act, 69'(0));
        check("R1 reset done", 69'(done), 69'(0));
        rst_n = 1'b1;
        @(negedge clk);
        // R1: empty array misses
        sr(1'b0, 8'h00, 64'h0, 5'd0, "R1 empty search");
        // R2/R5: write slot 5, then hit with junk in ignored rb bits (R3)
        wr(1'b1, 2'd1, '{1'b1, 1'b1, 8'h12, 20'hABCDE, 5'h15, 20'h12345, 6'h2A, 4'h9}, 5'd0, "R2 write");
        sr(1'b1, 8'h12, 64'hFFFF_FFFF_ABCD_E345, 5'd0, "R5 hit fields");
        sr(1'b0, 8'h12, 64'h0000_0000_ABCD_E000, 5'd0, "R3 wrong AS miss");
        sr(1'b1, 8'h13, 64'h0000_0000_ABCD_E000, 5'd0, "R4 wrong PID miss");
        sr(1'b1, 8'h12, 64'h0000_0000_ABCD_F000, 5'd0, "R6 wrong page miss");
        // R4: global entry
        wr(1'b0, 2'd2, '{1'b1, 1'b0, 8'h00, 20'h11111, 5'h01, 20'h0F0F0, 6'h03, 4'hF}, 5'd0, "R2 write global");
        sr(1'b0, 8'h77, 64'h0000_0000_1111_1ABC, 5'd0, "R4 global hit");
        // R7: priority
        wr(1'b1, 2'd3, '{1'b1, 1'b0, 8'h40, 20'h22222, 5'h02, 20'h77777, 6'h07, 4'h7}, 5'd0, "R2 write slot7");
        wr(1'b0, 2'd3, '{1'b1, 1'b0, 8'h40, 20'h22222, 5'h03, 20'h33333, 6'h13, 4'h3}, 5'd0, "R2 write slot3");
        wr(1'b0, 2'd1, '{1'b0, 1'b0, 8'h40, 20'h22222, 5'h04, 20'h11111, 6'h11, 4'h1}, 5'd7, "R8 write ignores RA");
        sr(1'b0, 8'h40, 64'h0000_0000_2222_2000, 5'd0, "R7 lowest slot wins");
        // R8: refused search keeps outputs
        sr(1'b1, 8'h12, 64'h0000_0000_ABCD_E000, 5'd1, "R8 trap keeps outputs");
        // R9: back-to-back write then search
        wr(1'b0, 2'd0, '{1'b1, 1'b1, 8'h55, 20'h00042, 5'h1F, 20'hABABA, 6'h3F, 4'h5}, 5'd0, "R9 back-to-back write");
        sr(1'b1, 8'h55, 64'h0000_0000_0004_2FFF, 5'd0, "R9 back-to-back search");
        // R2: overwrite slot 3 invalid, slot 7 now wins (R7)
        wr(1'b0, 2'd3, '0, 5'd0, "R2 overwrite");
        sr(1'b0, 8'h40, 64'h0000_0000_2222_2000, 5'd0, "R2 replaced entry");
        repeat (3) @(negedge clk);
        check("R9 idle done low", 69'(done), 69'(0));
        check("R9 all results seen", 69'(sb.size()), 69'(0));
        finish_run();
    end
endmodule